// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block decides, cycle by cycle, which hardware thread the instruction fetch stage works on. Each thread reports a 3-bit fetch state. The selector checks those states against an ordered priority list of thread indices. It presents a grant flag and the chosen thread index combinationally, in the same cycle as its inputs.

In round-robin mode the list is scanned from head to tail, and the first thread that may fetch wins. When the fetch stage raises its grant strobe, the winner leaves its place in the list and goes to the tail at the next clock edge. In single-thread mode, or when only one thread is configured, the list plays no part and thread 0 is the only candidate. The number of configured threads comes in on a port, so threads above that count are never chosen.

Top module: `fetch_thread_sel`

## Requirements
- R1: Fetch-state codes: 0 running, 1 idle, 2 squashing, 3 blocked, 4 trap wait, 5 quiesce wait, 6 miss outstanding, 7 miss returned. Only codes 0, 1 and 7 make a thread eligible. Thread i's code sits in `thr_state[3*i+2:3*i]`.
- R2: In round-robin mode (`mode_rr`=1) with a count above 1, the grant goes to the first eligible thread found scanning the list from head to tail.
- R3: A round-robin grant taken with `pick_req`=1 moves the granted thread to the tail at the next clock edge. The other entries close up and keep their relative order.
- R4: If no thread is eligible in round-robin mode, `pick_valid` is 0 and the list is unchanged, whatever `pick_req` is.
- R5: After reset the list holds 0,1,2,3 from head to tail.
- R6: With `thr_count`=1, the mode is ignored. Thread 0 is granted exactly when it is eligible, and the list is unchanged.
- R7: In single-thread mode (`mode_rr`=0) with a count above 1, `pick_valid`=1 and `pick_tid`=0, whatever the states are, and the list is unchanged.
- R8: With `pick_req`=0 the list is unchanged.
- R9: A thread whose index is not below `thr_count` is never granted. With `thr_count`=0 there is no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pick_req | input | 1 | Fetch takes the current grant this cycle |
| mode_rr | input | 1 | 1 round-robin, 0 single-thread |
| thr_count | input | 3 | Number of configured threads |
| thr_state | input | 12 | Per-thread 3-bit fetch state |
| pick_valid | output | 1 | A thread is granted |
| pick_tid | output | 2 | Granted thread index |

## Verification
The grant outputs depend only on the inputs and the stored list, so they are due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and compares the outputs a moment later, before the next rising edge. The list reorder happens at the rising edge that follows a taken grant. It therefore shows up only in the grants of later cycles. The bench keeps its own copy of the list, updates it at that same edge, and predicts every later grant from that copy.

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel #(
  parameter int NTHR = 4,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CW = $clog2(NTHR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pick_req,
  input  logic              mode_rr,
  input  logic [CW-1:0]     thr_count,
  input  logic [NTHR*3-1:0] thr_state,
  output logic              pick_valid,
  output logic [TW-1:0]     pick_tid
);

  logic [TW-1:0]      order_q [NTHR];
  logic [NTHR-1:0]    elig;
  logic [NTHR*TW-1:0] order_flat;
  logic               hit;
  logic [TW-1:0]      pos;
  logic               multi;
  logic               rotate;

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    logic [2:0] st;
    assign st = thr_state[3*i +: 3];
    assign elig[i] = (st == 3'd0 || st == 3'd1 || st == 3'd7) && (CW'(i) < thr_count);
    assign order_flat[TW*i +: TW] = order_q[i];
  end

  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = 0; p < NTHR; p++) begin
      if (!hit && elig[order_q[p]]) begin
        hit = 1'b1;
        pos = TW'(p);
      end
    end
  end

  assign multi      = thr_count > CW'(1);
  assign pick_valid = (thr_count == CW'(1)) ? elig[0] :
                      !multi ? 1'b0 :
                      mode_rr ? hit : 1'b1;
  assign pick_tid   = (multi && mode_rr) ? order_q[pos] : '0;
  assign rotate     = pick_req && mode_rr && multi && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTHR; i++) order_q[i] <= TW'(i);
    end else if (rotate) begin
      for (int p = 0; p < NTHR - 1; p++)
        if (TW'(p) >= pos) order_q[p] <= order_q[p+1];
      order_q[NTHR-1] <= order_q[pos];
    end
  end

endmodule

// File: rtl/fetch_thread_sel_chk.sv
module fetch_thread_sel_chk #(
  parameter int NTHR = 4,
  parameter int TW = 2,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pick_req,
  input logic              mode_rr,
  input logic [CW-1:0]     thr_count,
  input logic [NTHR*3-1:0] thr_state,
  input logic              pick_valid,
  input logic [TW-1:0]     pick_tid,
  input logic [NTHR*TW-1:0] order_flat
);

  logic [2:0] gst;
  assign gst = thr_state[3*pick_tid +: 3];

  // R1
  granted_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && mode_rr && thr_count > CW'(1)) |-> (gst == 3'd0 || gst == 3'd1 || gst == 3'd7));

  // R9
  tid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (CW'(pick_tid) < thr_count));

  // R7
  single_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rr && thr_count > CW'(1)) |-> (pick_valid && pick_tid == '0));

  // R3
  winner_to_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_req && pick_valid && mode_rr && thr_count > CW'(1)) |=>
      (order_flat[TW*(NTHR-1) +: TW] == $past(pick_tid)));

  // R8
  hold_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_req |=> $stable(order_flat));

endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(.NTHR(NTHR), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pick_req(pick_req), .mode_rr(mode_rr),
  .thr_count(thr_count), .thr_state(thr_state), .pick_valid(pick_valid),
  .pick_tid(pick_tid), .order_flat(order_flat)
);

// File: tb/fetch_thread_sel_bench.sv
module fetch_thread_sel_bench;
  localparam int PER = 10;
  localparam int N = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic pick_req = 0;
  logic mode_rr = 1;
  logic [2:0] thr_count = 3'd4;
  logic [11:0] thr_state = '0;
  logic pick_valid;
  logic [1:0] pick_tid;

  int total = 0;
  int bad = 0;
  int mdl [N];
  bit done = 0;

  always #(PER/2) clk = ~clk;

  fetch_thread_sel u_fetch_thread_sel (
    .clk(clk), .rst_n(rst_n), .pick_req(pick_req), .mode_rr(mode_rr),
    .thr_count(thr_count), .thr_state(thr_state),
    .pick_valid(pick_valid), .pick_tid(pick_tid)
  );

  function automatic bit ok_code(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1 || c == 3'd7;
  endfunction

  function automatic bit elig_b(input int t);
    return (t < int'(thr_count)) && ok_code(thr_state[3*t +: 3]);
  endfunction

  function automatic int exp_pos();
    for (int p = 0; p < N; p++) if (elig_b(mdl[p])) return p;
    return -1;
  endfunction

  task automatic check(input string req, input bit ev, input int et);
    total++;
    if (pick_valid !== ev || (ev && int'(pick_tid) != et)) begin
      bad++;
      $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, pick_valid, pick_tid, ev, et);
    end
  endtask

  task automatic cyc(input string req, input bit rq, input bit rr,
                     input logic [2:0] cnt, input logic [11:0] st);
    bit ev;
    int et;
    int p;
    @(negedge clk);
    pick_req = rq; mode_rr = rr; thr_count = cnt; thr_state = st;
    #1;
    p = -1;
    et = 0;
    if (cnt == 3'd1) ev = elig_b(0);
    else if (cnt == 3'd0) ev = 0;
    else if (!rr) ev = 1;
    else begin
      p = exp_pos();
      ev = (p >= 0);
      if (ev) et = mdl[p];
    end
    check(req, ev, et);
    @(posedge clk);
    if (rq && rr && cnt > 3'd1 && p >= 0) begin
      for (int k = p; k < N - 1; k++) mdl[k] = mdl[k+1];
      mdl[N-1] = et;
    end
  endtask

  function automatic logic [11:0] all_st(input logic [2:0] c);
    return {c, c, c, c};
  endfunction

  initial begin
    #(PER * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) mdl[i] = i;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R5: ascending order after reset, granted in turn
    cyc("R5", 1, 1, 3'd4, all_st(3'd1));
    cyc("R5", 1, 1, 3'd4, all_st(3'd1));
    cyc("R5", 1, 1, 3'd4, all_st(3'd1));
    cyc("R5", 1, 1, 3'd4, all_st(3'd1));
    // R1: each code on thread 0 with a single thread
    for (int c = 0; c < 8; c++) cyc("R1_R6", 0, 1, 3'd1, {9'h0, 3'(c)});
    // R6: mode ignored with one thread
    cyc("R6", 1, 0, 3'd1, 12'h003);
    cyc("R6", 1, 0, 3'd1, 12'h007);
    // R2: first eligible from head; thread 0,1 blocked
    cyc("R2", 1, 1, 3'd4, {3'd0, 3'd7, 3'd3, 3'd3});
    // R4: none eligible, list must hold
    cyc("R4", 1, 1, 3'd4, all_st(3'd6));
    cyc("R4", 1, 1, 3'd4, all_st(3'd2));
    cyc("R4", 1, 1, 3'd4, all_st(3'd0));
    // R8: without strobe the same thread stays granted
    cyc("R8", 0, 1, 3'd4, all_st(3'd0));
    cyc("R8", 0, 1, 3'd4, all_st(3'd0));
    // R7: single-thread mode, states ignored, list holds
    cyc("R7", 1, 0, 3'd4, all_st(3'd3));
    cyc("R7", 1, 0, 3'd3, all_st(3'd1));
    cyc("R3", 1, 1, 3'd4, all_st(3'd1));
    // R9: count limits, zero count
    cyc("R9", 1, 1, 3'd2, {3'd0, 3'd0, 3'd5, 3'd4});
    cyc("R9", 1, 1, 3'd0, all_st(3'd0));
    cyc("R9", 1, 1, 3'd2, all_st(3'd0));
    cyc("R9", 1, 1, 3'd2, all_st(3'd0));
    // R3: random traffic against the list model
    for (int n = 0; n < 600; n++) begin
      logic [2:0] cnt;
      cnt = 3'($urandom_range(0, 4));
      if ($urandom_range(0, 3) != 0) cnt = 3'd4;
      cyc("R3", 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 7) != 0),
          cnt, 12'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule